// File: doc/BRIEF.md
# Bus Deadlock Watchdog

This block sits beside an on-chip interconnect and watches a set of bus masters for requests that never get an answer. Each master has a single tracking slot. A request handshake pulse loads the slot with the target slave index, the transaction ID and a write/read flag. A response handshake pulse empties the slot. While the slot is waiting, a cycle counter runs against a programmable threshold. If the count reaches the threshold before a response arrives, that master has timed out.

When one or more masters time out in a cycle, the lowest-numbered one is chosen. Its details are packed into a status word, and a sticky raw interrupt bit is set. The status word then stays frozen until software clears the raw bit. A small register port gives access to the threshold, an enable bit, the raw and masked interrupt bits, a write-one-to-clear register and the status word.

Each slot runs a state machine with three states. In SLOT_IDLE, a request moves the slot to SLOT_WAIT. In SLOT_WAIT, a response moves it back to SLOT_IDLE, and reaching the limit moves it to SLOT_EXPIRED. In SLOT_EXPIRED, a late response moves it to SLOT_IDLE. The capture unit has two states. In CAP_ARMED, a timeout event captures the status word and moves to CAP_HELD. In CAP_HELD, a clear with no timeout event in the same cycle returns to CAP_ARMED.

Top module: `dlock_mon`

## Requirements
- R1: The threshold register (address 0, bits [12:0]) resets to 2048 and reads back what was written.
- R2: Take a request accepted at clock edge k, with threshold T and no response. The raw bit (address 2, bit 0) becomes 1 at edge k+T. A response presented at any edge from k+1 through k+T prevents the timeout, and the next request starts a fresh count.
- R3: When several masters time out in the same cycle, the reported master is the lowest-numbered one.
- R4: The status word (address 5) holds the master number in bits [3:0], the slave index in [6:4], the ID in [10:7] and a write flag in bit 11 (1 = write). It reads 0 while the raw bit is 0. Writes to it are ignored.
- R5: Once set, the raw bit stays set. Writing 1 to bit 0 of the clear register (address 4) clears it. Writing 0 there has no effect, and reading that register returns 0.
- R6: The enable bit (address 1, bit 0) resets to 1. The irq output and the masked register (address 3, bit 0) both equal the raw bit ANDed with the enable bit.
- R7: The status word is frozen from the timeout that set the raw bit until that bit is cleared. Later timeouts do not change it.
- R8: A timeout in the same cycle as a clear write leaves the raw bit set and the status word unchanged.
- R9: A threshold of 0 disables timeout detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_vld | input | 16 | Per-master request handshake pulse |
| req_slv | input | 48 | Per-master slave index, 3 bits per master |
| req_id | input | 64 | Per-master transaction ID, 4 bits per master |
| req_wr | input | 16 | Per-master write flag |
| rsp_vld | input | 16 | Per-master response handshake pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Masked deadlock interrupt |

## Verification
The following properties are checked on every cycle:
- the raw bit only rises one cycle after a timeout event, and only falls after a clear write;
- a timeout that lands on a clear write keeps the raw bit set;
- the status word does not move while the raw bit is held;
- the captured master number matches the lowest timeout event.

The exact cycle at which a timeout fires, the field packing, the reset values, the effect of a zero threshold and the masking by the enable bit can only be shown by the bench's scenarios, which drive requests, responses and register traffic at chosen cycles.

// File: rtl/dlock_pkg.sv
package dlock_pkg;

    localparam int REG_AW = 3;
    localparam int REG_DW = 32;

    localparam logic [REG_AW-1:0] REG_THR = 3'd0;
    localparam logic [REG_AW-1:0] REG_ENA = 3'd1;
    localparam logic [REG_AW-1:0] REG_RAW = 3'd2;
    localparam logic [REG_AW-1:0] REG_MSK = 3'd3;
    localparam logic [REG_AW-1:0] REG_CLR = 3'd4;
    localparam logic [REG_AW-1:0] REG_STS = 3'd5;

    typedef enum logic [1:0] {
        SLOT_IDLE    = 2'd0,
        SLOT_WAIT    = 2'd1,
        SLOT_EXPIRED = 2'd2
    } slot_state_e;

    typedef enum logic {
        CAP_ARMED = 1'b0,
        CAP_HELD  = 1'b1
    } cap_state_e;

endpackage

// File: rtl/dlock_slot.sv
module dlock_slot
    import dlock_pkg::*;
#(
    parameter int SLV_W = 3,
    parameter int ID_W  = 4,
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             rsp,
    input  logic [SLV_W-1:0] slv_in,
    input  logic [ID_W-1:0]  id_in,
    input  logic             wr_in,
    input  logic [CNT_W-1:0] thr,
    output logic             expire,
    output logic [SLV_W-1:0] slv_q,
    output logic [ID_W-1:0]  id_q,
    output logic             wr_q
);

    slot_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             limit_hit;

    assign cnt_inc   = cnt_q + CNT_W'(1);
    assign limit_hit = (thr != '0) && (cnt_inc >= thr);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_IDLE: begin
                if (req) state_d = SLOT_WAIT;
            end
            SLOT_WAIT: begin
                if (rsp)            state_d = SLOT_IDLE;
                else if (limit_hit) state_d = SLOT_EXPIRED;
            end
            SLOT_EXPIRED: begin
                if (rsp) state_d = SLOT_IDLE;
            end
            default: state_d = SLOT_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_IDLE;
        else        state_q <= state_d;
    end

    // wait counter and captured transaction fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            slv_q <= '0;
            id_q  <= '0;
            wr_q  <= 1'b0;
        end else begin
            if (state_q == SLOT_IDLE && req) begin
                cnt_q <= '0;
                slv_q <= slv_in;
                id_q  <= id_in;
                wr_q  <= wr_in;
            end else if (state_q == SLOT_WAIT) begin
                if (rsp)             cnt_q <= '0;
                else if (!limit_hit) cnt_q <= cnt_inc;
            end else if (state_q == SLOT_EXPIRED && rsp) begin
                cnt_q <= '0;
            end
        end
    end

    // outputs: one-cycle timeout event
    always_comb begin
        expire = (state_q == SLOT_WAIT) && !rsp && limit_hit;
    end

endmodule

// File: rtl/dlock_pick.sv
module dlock_pick #(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     hits,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/dlock_cap.sv
module dlock_cap
    import dlock_pkg::*;
#(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set,
    input  logic              clr,
    input  logic [WORD_W-1:0] word_in,
    output logic              raw,
    output logic [WORD_W-1:0] word_q
);

    cap_state_e state_q, state_d;

    // next state: a set in the same cycle as a clear keeps the hold
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAP_ARMED: begin
                if (set) state_d = CAP_HELD;
            end
            CAP_HELD: begin
                if (clr && !set) state_d = CAP_ARMED;
            end
            default: state_d = CAP_ARMED;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CAP_ARMED;
        else        state_q <= state_d;
    end

    // captured word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (state_q == CAP_ARMED && set) begin
            word_q <= word_in;
        end else if (state_q == CAP_HELD && clr && !set) begin
            word_q <= '0;
        end
    end

    // outputs
    always_comb begin
        raw = (state_q == CAP_HELD);
    end

endmodule

// File: rtl/dlock_regs.sv
module dlock_regs
    import dlock_pkg::*;
#(
    parameter int TMO_W   = 13,
    parameter int TMO_RST = 2048,
    parameter int STS_W   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    input  logic              raw,
    input  logic [STS_W-1:0]  status,
    output logic [TMO_W-1:0]  thr_q,
    output logic              clr,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              irq
);

    logic en_q;
    logic unused_wdata;

    assign unused_wdata = ^reg_wdata[REG_DW-1:TMO_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_q <= TMO_W'(TMO_RST);
            en_q  <= 1'b1;
        end else if (reg_we) begin
            if (reg_addr == REG_THR) thr_q <= reg_wdata[TMO_W-1:0];
            if (reg_addr == REG_ENA) en_q  <= reg_wdata[0];
        end
    end

    assign clr = reg_we && (reg_addr == REG_CLR) && reg_wdata[0];
    assign irq = raw & en_q;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_THR: reg_rdata = REG_DW'(thr_q);
            REG_ENA: reg_rdata = REG_DW'(en_q);
            REG_RAW: reg_rdata = REG_DW'(raw);
            REG_MSK: reg_rdata = REG_DW'(irq);
            REG_STS: reg_rdata = REG_DW'(status);
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dlock_mon.sv
module dlock_mon
    import dlock_pkg::*;
#(
    parameter int NUM_MST = 16,
    parameter int SLV_W   = 3,
    parameter int ID_W    = 4,
    parameter int TMO_W   = 13,
    parameter int TMO_RST = 2048
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_MST-1:0]       req_vld,
    input  logic [NUM_MST*SLV_W-1:0] req_slv,
    input  logic [NUM_MST*ID_W-1:0]  req_id,
    input  logic [NUM_MST-1:0]       req_wr,
    input  logic [NUM_MST-1:0]       rsp_vld,
    input  logic                     reg_we,
    input  logic [REG_AW-1:0]        reg_addr,
    input  logic [REG_DW-1:0]        reg_wdata,
    output logic [REG_DW-1:0]        reg_rdata,
    output logic                     irq
);

    localparam int MST_W = (NUM_MST > 1) ? $clog2(NUM_MST) : 1;
    localparam int STS_W = MST_W + SLV_W + ID_W + 1;

    logic [NUM_MST-1:0] expire_vec;
    logic [SLV_W-1:0]   slot_slv [NUM_MST];
    logic [ID_W-1:0]    slot_id  [NUM_MST];
    logic [NUM_MST-1:0] slot_wr;
    logic [TMO_W-1:0]   thr_q;
    logic               hit_any;
    logic [MST_W-1:0]   hit_idx;
    logic [STS_W-1:0]   sts_next;
    logic [STS_W-1:0]   status_q;
    logic               raw_q;
    logic               clr_evt;

    for (genvar g = 0; g < NUM_MST; g++) begin : g_slot
        dlock_slot #(
            .SLV_W (SLV_W),
            .ID_W  (ID_W),
            .CNT_W (TMO_W)
        ) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .req    (req_vld[g]),
            .rsp    (rsp_vld[g]),
            .slv_in (req_slv[g*SLV_W +: SLV_W]),
            .id_in  (req_id[g*ID_W +: ID_W]),
            .wr_in  (req_wr[g]),
            .thr    (thr_q),
            .expire (expire_vec[g]),
            .slv_q  (slot_slv[g]),
            .id_q   (slot_id[g]),
            .wr_q   (slot_wr[g])
        );
    end

    dlock_pick #(
        .N     (NUM_MST),
        .IDX_W (MST_W)
    ) u_pick (
        .hits  (expire_vec),
        .found (hit_any),
        .idx   (hit_idx)
    );

    assign sts_next = {slot_wr[hit_idx], slot_id[hit_idx], slot_slv[hit_idx], hit_idx};

    dlock_cap #(
        .WORD_W (STS_W)
    ) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .set     (hit_any),
        .clr     (clr_evt),
        .word_in (sts_next),
        .raw     (raw_q),
        .word_q  (status_q)
    );

    dlock_regs #(
        .TMO_W   (TMO_W),
        .TMO_RST (TMO_RST),
        .STS_W   (STS_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .raw       (raw_q),
        .status    (status_q),
        .thr_q     (thr_q),
        .clr       (clr_evt),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

endmodule

// File: rtl/dlock_chk.sv
module dlock_chk
    import dlock_pkg::*;
#(
    parameter int NUM_MST = 16,
    parameter int STS_W   = 12,
    parameter int MST_W   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               raw_q,
    input logic [STS_W-1:0]   status_q,
    input logic [NUM_MST-1:0] expire_vec,
    input logic               reg_we,
    input logic [REG_AW-1:0]  reg_addr,
    input logic               clr_bit
);

    logic               clr_seen;
    logic [MST_W-1:0]   sts_mst;
    logic [NUM_MST-1:0] low_mask;

    assign clr_seen = reg_we && (reg_addr == REG_CLR) && clr_bit;
    assign sts_mst  = status_q[MST_W-1:0];
    assign low_mask = (NUM_MST'(1) << sts_mst) - NUM_MST'(1);

    assert_raw_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw_q) |-> $past(|expire_vec));

    assert_raw_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(raw_q) |-> $past(clr_seen));

    assert_status_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_q && !clr_seen) |=> $stable(status_q));

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_q && clr_seen && (|expire_vec)) |=> raw_q);

    assert_lowest_master_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw_q) |-> ((($past(expire_vec) & low_mask) == '0) &&
                          ((($past(expire_vec) >> sts_mst) & NUM_MST'(1)) != '0)));

endmodule

bind dlock_mon dlock_chk #(
    .NUM_MST (NUM_MST),
    .STS_W   (STS_W),
    .MST_W   (MST_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .raw_q      (raw_q),
    .status_q   (status_q),
    .expire_vec (expire_vec),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .clr_bit    (reg_wdata[0])
);

// File: tb/tb_dlock_mon.sv
module tb_dlock_mon;

    localparam int CLK_PERIOD = 10;
    localparam int NM         = 16;

    typedef struct packed {
        logic [3:0]  m;
        logic [2:0]  s;
        logic [3:0]  id;
        logic        w;
        logic [12:0] thr;
        logic [12:0] at;   // response cycle, 0 = never
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{4'd0,  3'd1, 4'd2,  1'b0, 13'd4, 13'd0},
        '{4'd15, 3'd7, 4'd15, 1'b1, 13'd6, 13'd0},
        '{4'd3,  3'd2, 4'd9,  1'b1, 13'd5, 13'd5},
        '{4'd7,  3'd5, 4'd4,  1'b0, 13'd5, 13'd6},
        '{4'd9,  3'd3, 4'd1,  1'b1, 13'd0, 13'd0},
        '{4'd12, 3'd6, 4'd10, 1'b0, 13'd1, 13'd0},
        '{4'd4,  3'd0, 4'd0,  1'b1, 13'd8, 13'd2},
        '{4'd1,  3'd4, 4'd6,  1'b1, 13'd3, 13'd4}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NM-1:0]   req_vld = '0;
    logic [NM*3-1:0] req_slv = '0;
    logic [NM*4-1:0] req_id = '0;
    logic [NM-1:0]   req_wr = '0;
    logic [NM-1:0]   rsp_vld = '0;
    logic            reg_we = 1'b0;
    logic [2:0]      reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic            irq;

    int nvec = 0;
    int nmis = 0;
    bit done = 1'b0;

    dlock_mon dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_vld   (req_vld),
        .req_slv   (req_slv),
        .req_id    (req_id),
        .req_wr    (req_wr),
        .rsp_vld   (rsp_vld),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nmis++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic load(input int m, input int s, input int id, input bit w);
        req_slv[m*3 +: 3] = 3'(s);
        req_id[m*4 +: 4]  = 4'(id);
        req_wr[m]         = w;
        req_vld[m]        = 1'b1;
    endtask

    task automatic issue(input int m, input int s, input int id, input bit w);
        load(m, s, id, w);
        @(negedge clk);
        req_vld = '0;
    endtask

    task automatic respond(input int m);
        rsp_vld[m] = 1'b1;
        @(negedge clk);
        rsp_vld = '0;
    endtask

    function automatic logic [31:0] sts(input int m, input int s, input int id, input bit w);
        return {20'b0, w, 4'(id), 3'(s), 4'(m)};
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            nmis++;
            $display("FAIL watchdog: got %h expected %h", 32'd0, 32'd1);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        rd_reg(3'd0, v); chk("R1 threshold reset", v, 32'd2048);
        rd_reg(3'd1, v); chk("R6 enable reset", v, 32'd1);
        rd_reg(3'd2, v); chk("R5 raw reset", v, 32'd0);
        rd_reg(3'd5, v); chk("R4 status reset", v, 32'd0);
        chk("R6 irq reset", 32'(irq), 32'd0);
        wr_reg(3'd0, 32'h0000_1ABC);
        rd_reg(3'd0, v); chk("R1 threshold readback", v, 32'h0000_1ABC);

        // vector table
        for (int n = 0; n < 8; n++) begin
            vec_t t;
            int lim;
            bit exp_raw;
            t = VECS[n];
            lim = (t.thr == 0) ? 20 : int'(t.thr) + 3;
            exp_raw = (t.thr != 0) && (t.at == 0 || t.at > t.thr);
            wr_reg(3'd0, 32'(t.thr));
            issue(int'(t.m), int'(t.s), int'(t.id), t.w);
            for (int c = 1; c <= lim; c++) begin
                rsp_vld[t.m] = (c == int'(t.at));
                @(negedge clk);
            end
            rsp_vld = '0;
            if (t.at == 0) respond(int'(t.m));
            rd_reg(3'd2, v); chk("R2/R9 vector raw", v, 32'(exp_raw));
            rd_reg(3'd5, v);
            chk("R4 vector status", v, exp_raw ? sts(int'(t.m), int'(t.s), int'(t.id), t.w) : 32'd0);
            chk("R6 vector irq", 32'(irq), 32'(exp_raw));
            wr_reg(3'd4, 32'd1);
            rd_reg(3'd2, v); chk("R5 vector cleared", v, 32'd0);
        end

        // R2 exact cycle of timeout
        wr_reg(3'd0, 32'd5);
        issue(6, 2, 3, 1'b0);
        repeat (4) @(negedge clk);
        rd_reg(3'd2, v); chk("R2 raw not yet", v, 32'd0);
        @(negedge clk);
        rd_reg(3'd2, v); chk("R2 raw at threshold", v, 32'd1);
        respond(6);
        wr_reg(3'd4, 32'd1);

        // R3 simultaneous timeouts
        wr_reg(3'd0, 32'd4);
        load(9, 1, 7, 1'b1);
        load(6, 5, 12, 1'b0);
        @(negedge clk);
        req_vld = '0;
        repeat (6) @(negedge clk);
        rd_reg(3'd5, v); chk("R3 lowest master", v, sts(6, 5, 12, 1'b0));
        respond(6); respond(9);
        wr_reg(3'd4, 32'd1);

        // R7 frozen status
        wr_reg(3'd0, 32'd3);
        issue(2, 3, 5, 1'b1);
        repeat (5) @(negedge clk);
        issue(11, 6, 8, 1'b0);
        repeat (5) @(negedge clk);
        rd_reg(3'd5, v); chk("R7 status frozen", v, sts(2, 3, 5, 1'b1));
        wr_reg(3'd5, 32'hFFF);
        rd_reg(3'd5, v); chk("R4 status write ignored", v, sts(2, 3, 5, 1'b1));
        respond(2); respond(11);
        wr_reg(3'd4, 32'd1);

        // R6 enable masking
        wr_reg(3'd1, 32'd0);
        issue(5, 4, 2, 1'b0);
        repeat (5) @(negedge clk);
        rd_reg(3'd2, v); chk("R6 raw with enable off", v, 32'd1);
        chk("R6 irq masked", 32'(irq), 32'd0);
        rd_reg(3'd3, v); chk("R6 masked reg off", v, 32'd0);
        wr_reg(3'd1, 32'd1);
        chk("R6 irq enabled", 32'(irq), 32'd1);
        rd_reg(3'd3, v); chk("R6 masked reg on", v, 32'd1);
        respond(5);
        wr_reg(3'd4, 32'd1);

        // R8 set wins over clear; R5 write of 0 ignored
        wr_reg(3'd0, 32'd4);
        issue(0, 1, 1, 1'b1);
        repeat (6) @(negedge clk);
        respond(0);
        issue(8, 7, 3, 1'b0);
        repeat (3) @(negedge clk);
        wr_reg(3'd4, 32'd1);
        rd_reg(3'd2, v); chk("R8 raw kept on collision", v, 32'd1);
        rd_reg(3'd5, v); chk("R8 status kept", v, sts(0, 1, 1, 1'b1));
        wr_reg(3'd4, 32'd0);
        rd_reg(3'd2, v); chk("R5 zero write no clear", v, 32'd1);
        rd_reg(3'd4, v); chk("R5 clear reads zero", v, 32'd0);
        respond(8);
        wr_reg(3'd4, 32'd1);
        rd_reg(3'd2, v); chk("R5 final clear", v, 32'd0);
        rd_reg(3'd5, v); chk("R4 status zero after clear", v, 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
        $finish;
    end

endmodule